// File: doc/BRIEF.md
# Dual-Channel Edge Activity Indicator

This block lights one activity lamp for each of two capture channels. Each channel sends a single-cycle event strobe every time it finishes a block of edge samples. On each event the block measures how long it has been since that channel's previous event, using a shared free-running microsecond timestamp. It then updates a leaky accumulator for that channel. Each event adds a fixed credit, and the elapsed gap is taken away from it.

A lamp stays lit while its accumulator holds a nonzero value. A channel that reports often keeps its lamp on. A channel that goes quiet lets its accumulator drain to zero at the next event, and its lamp goes dark. The lamp outputs are active-low. Bit 0 drives the lamp colour for channel 0 and bit 1 drives the lamp colour for channel 1.

The two channels keep fully separate state. Events on both channels in the same cycle are each handled in that cycle.

Top module: `act_indicator_top`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulators and both stored timestamps are zero, so both lamp outputs read 1 (dark). The first event on a channel therefore measures its gap from timestamp 0.
- R2: Each channel owns its accumulator and its stored timestamp. An event on one channel leaves the other channel's lamp and state untouched.
- R3: On an event, gap = nowUs − stored timestamp, computed modulo 2^32. The stored timestamp is then replaced by nowUs.
- R4: A gap whose bit 31 is set is a negative value and counts as 0.
- R5: On an event the accumulator becomes max(0, accumulator + CREDIT − gap), with CREDIT = 30000 by default.
- R6: The accumulator saturates at its all-ones maximum (ACC_W bits, 32 by default) instead of wrapping.
- R7: lampN[i] is 0 (lit) exactly when accumulator i is nonzero.
- R8: Events on both channels in the same cycle are both processed in that cycle, each against its own state.
- R9: Without an event, a channel's accumulator and stored timestamp hold, whatever nowUs does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chEvent | input | 2 | Per-channel event strobe, one cycle per completed sample block |
| nowUs | input | TS_W (32) | Free-running microsecond timestamp |
| lampN | output | 2 | Active-low lamps; bit 0 for channel 0, bit 1 for channel 1 |

## Verification
The bench drives event trains with gaps just below, at and just above the credit. This pins the exact point where the accumulator drains to zero, and so checks the accumulator value itself and not only its sign. A timestamp that wraps past 2^32 and a timestamp that goes backwards tell modular subtraction apart from negative clamping. A long run of zero-gap events on a narrowed accumulator tells saturation apart from wrapping. Both-channel strobes with different histories, and idle cycles in which only the timestamp moves, show that the channels stay separate and that state holds between events.

// File: rtl/act_ind_pkg.sv
`timescale 1ns/1ps
package act_ind_pkg;
  localparam int unsigned CH_COUNT = 2;

  typedef struct packed {
    logic [CH_COUNT-1:0] update;
  } act_strobe_t;
endpackage

// File: rtl/act_ind_ctrl.sv
`timescale 1ns/1ps
module act_ind_ctrl
  import act_ind_pkg::*;
(
  input  logic [CH_COUNT-1:0] chEvent,
  output act_strobe_t         strobe
);
  // Each channel event becomes an update strobe in the same cycle, independently.
  always_comb begin
    strobe = '0;
    for (int i = 0; i < CH_COUNT; i++) begin
      strobe.update[i] = chEvent[i];
    end
  end
endmodule

// File: rtl/act_ind_chan.sv
`timescale 1ns/1ps
module act_ind_chan #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CREDIT = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             update,
  input  logic [TS_W-1:0]  nowUs,
  output logic [ACC_W-1:0] accValue,
  output logic             lampN
);
  localparam int unsigned WIDE_W = ((ACC_W > TS_W) ? ACC_W : TS_W) + 2;

  logic [TS_W-1:0]   lastTsQ;
  logic [ACC_W-1:0]  accQ;
  logic [ACC_W-1:0]  accD;
  logic [TS_W-1:0]   gapRaw;
  logic [WIDE_W-1:0] gapPos;
  logic [WIDE_W-1:0] sumWide;
  logic [WIDE_W-1:0] diffWide;
  logic [WIDE_W-1:0] maxWide;

  always_comb begin
    gapRaw   = nowUs - lastTsQ;
    gapPos   = gapRaw[TS_W-1] ? '0 : WIDE_W'(gapRaw);
    sumWide  = WIDE_W'(accQ) + WIDE_W'(CREDIT);
    diffWide = (sumWide > gapPos) ? (sumWide - gapPos) : '0;
    maxWide  = WIDE_W'({ACC_W{1'b1}});
    accD     = (diffWide > maxWide) ? {ACC_W{1'b1}} : diffWide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      lastTsQ <= '0;
    end else if (update) begin
      accQ    <= accD;
      lastTsQ <= nowUs;
    end
  end

  assign accValue = accQ;
  assign lampN    = (accQ == '0);
endmodule

// File: rtl/act_ind_dp.sv
`timescale 1ns/1ps
module act_ind_dp
  import act_ind_pkg::*;
#(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CREDIT = 30000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  act_strobe_t                     strobe,
  input  logic [TS_W-1:0]                 nowUs,
  output logic [CH_COUNT-1:0][ACC_W-1:0]  accAll,
  output logic [CH_COUNT-1:0]             lampN
);
  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    act_ind_chan #(.TS_W(TS_W), .ACC_W(ACC_W), .CREDIT(CREDIT)) chan_i (
      .clk      (clk),
      .rstN     (rstN),
      .update   (strobe.update[ch]),
      .nowUs    (nowUs),
      .accValue (accAll[ch]),
      .lampN    (lampN[ch])
    );
  end
endmodule

// File: rtl/act_indicator_top.sv
`timescale 1ns/1ps
module act_indicator_top
  import act_ind_pkg::*;
#(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CREDIT = 30000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] chEvent,
  input  logic [TS_W-1:0]     nowUs,
  output logic [CH_COUNT-1:0] lampN
);
  act_strobe_t                     strobe;
  logic [CH_COUNT-1:0][ACC_W-1:0]  accAll;

  act_ind_ctrl ctrl_i (
    .chEvent (chEvent),
    .strobe  (strobe)
  );

  act_ind_dp #(.TS_W(TS_W), .ACC_W(ACC_W), .CREDIT(CREDIT)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .nowUs  (nowUs),
    .accAll (accAll),
    .lampN  (lampN)
  );
endmodule

// File: rtl/act_ind_checker.sv
`timescale 1ns/1ps
module act_ind_checker
  import act_ind_pkg::*;
#(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned CREDIT = 30000
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [CH_COUNT-1:0]             chEvent,
  input logic [TS_W-1:0]                 nowUs,
  input logic [CH_COUNT-1:0]             lampN,
  input logic [CH_COUNT-1:0][ACC_W-1:0]  accVal
);
  AST_RESET_DARK: assert property (@(posedge clk) !rstN |-> (&lampN)); // R1

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_chk
    logic [TS_W-1:0] shadowTs;
    logic [TS_W-1:0] gapRaw;
    logic [TS_W-1:0] gapUse;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadowTs <= '0;
      else if (chEvent[i]) shadowTs <= nowUs;
    end

    always_comb begin
      gapRaw = nowUs - shadowTs;
      gapUse = gapRaw[TS_W-1] ? '0 : gapRaw;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !chEvent[i] |=> $stable(accVal[i])); // R9

    AST_SHORT_GAP_LIT: assert property (@(posedge clk) disable iff (!rstN)
      (chEvent[i] && (gapUse < TS_W'(CREDIT))) |=> !lampN[i]); // R7

    AST_LONG_GAP_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
      (chEvent[i] && (gapUse >= TS_W'(CREDIT))) |=> (accVal[i] <= $past(accVal[i]))); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (chEvent[i] && (gapUse == '0)) |=> (accVal[i] >= $past(accVal[i]))); // R6
  end
endmodule

bind act_indicator_top act_ind_checker #(.TS_W(TS_W), .ACC_W(ACC_W), .CREDIT(CREDIT)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .chEvent (chEvent),
  .nowUs   (nowUs),
  .lampN   (lampN),
  .accVal  (accAll)
);

// File: tb/act_indicator_top_tb_top.sv
`timescale 1ns/1ps
module act_indicator_top_tb_top;
  localparam int unsigned ACCW = 20;
  localparam longint CRED = 30000;
  localparam longint AMAX = (longint'(1) << ACCW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chEvent = '0;
  logic [31:0] nowUs = '0;
  logic [1:0]  lampN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint      mAcc [2];
  logic [31:0] mLast [2];

  always #2.5 clk = ~clk;

  act_indicator_top #(.TS_W(32), .ACC_W(ACCW), .CREDIT(30000)) dut_i (
    .clk(clk), .rstN(rstN), .chEvent(chEvent), .nowUs(nowUs), .lampN(lampN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lamp actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input int ch, input logic [31:0] ts);
    logic [31:0] d;
    longint dv, v;
    d = ts - mLast[ch];
    dv = d[31] ? 0 : longint'(d);
    v = mAcc[ch] + CRED - dv;
    if (v < 0) v = 0;
    if (v > AMAX) v = AMAX;
    mAcc[ch] = v;
    mLast[ch] = ts;
  endtask

  task automatic fire(input logic [1:0] mask, input logic [31:0] ts, input string req);
    @(negedge clk);
    chEvent = mask;
    nowUs = ts;
    @(posedge clk);
    #1;
    chEvent = '0;
    for (int c = 0; c < 2; c++) if (mask[c]) modelStep(c, ts);
    for (int c = 0; c < 2; c++) check(req, lampN[c], mAcc[c] == 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    for (int c = 0; c < 2; c++) begin mAcc[c] = 0; mLast[c] = '0; end
    #12;
    check("R1", lampN[0], 1'b1);
    check("R1", lampN[1], 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", lampN[0], 1'b1);
    check("R1", lampN[1], 1'b1);

    // R1/R3: first gap measured from 0; exact drain point proves acc = 29900
    fire(2'b01, 32'd100, "R1");
    check("R2", lampN[1], 1'b1);
    fire(2'b01, 32'd60000, "R3");
    check("R5", lampN[0], 1'b1);

    // R5 boundary sweep around the credit on channel 0
    t = 32'd60000;
    t += 29999; fire(2'b01, t, "R5");  // acc 1, lit
    t += 30001; fire(2'b01, t, "R5");  // acc 0, dark
    t += 30000; fire(2'b01, t, "R5");  // acc 0, dark
    t += 15000; fire(2'b01, t, "R5");
    t += 15000; fire(2'b01, t, "R5");
    t += 45000; fire(2'b01, t, "R5");

    // R2/R5 mixed gaps, alternating and joint
    for (int k = 0; k < 300; k++) begin
      t += 32'((k * 7919) % 70000);
      fire(2'((k % 3) + 1), t, (k % 3 == 2) ? "R8" : "R2");
    end

    // R9: timestamp moves, no events; state must hold
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      nowUs = t + 32'(k * 100000);
      @(posedge clk); #1;
      check("R9", lampN[0], mAcc[0] == 0);
      check("R9", lampN[1], mAcc[1] == 0);
    end
    t += 10000; fire(2'b11, t, "R9");

    // R3: wraparound of the timestamp on channel 1
    fire(2'b10, 32'hFFFF_FF00, "R4");
    fire(2'b10, 32'h0000_0010, "R3");
    fire(2'b10, 32'h0000_0010 + 32'(mAcc[1] + CRED - 1), "R3");
    fire(2'b10, mLast[1] + 32'd30001, "R3");

    // R4: timestamp goes backwards
    t = mLast[1];
    fire(2'b10, t - 32'd5000, "R4");
    fire(2'b10, t - 32'd5000 + 32'(mAcc[1] + CRED), "R4");

    // R6: saturate channel 0 with zero gaps, then probe exact value
    t = mLast[0];
    for (int k = 0; k < 40; k++) fire(2'b01, t, "R6");
    fire(2'b01, t + 32'(AMAX + CRED - 1), "R6");
    check("R6", lampN[0], 1'b0);
    fire(2'b01, mLast[0] + 32'd30001, "R6");
    check("R6", lampN[0], 1'b1);

    // R8: joint event with different histories
    fire(2'b10, mLast[0] - 32'd1000, "R8");
    fire(2'b11, mLast[0] + 32'd29000, "R8");
    fire(2'b11, mLast[0] + 32'd60000, "R8");

    // R7: lamp follows zero/nonzero
    fire(2'b01, mLast[0], "R7");
    check("R7", lampN[0], 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule